// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits between an upstream host port and one PCI bus segment behind a bridge. It accepts configuration read and write requests that arrive as an address word in the standard "enable / bus / device / function / register" layout. It then decides whether the request is served on the local segment, passed on toward a bridge further downstream, or left unclaimed. For each claimed request it runs exactly one single-DWord transaction: one address phase followed by one data phase.

Routing depends on two bridge registers supplied as inputs: the secondary bus number (the local segment) and the subordinate bus number (the highest bus reachable downstream). A local request is emitted as a Type 0 cycle. Its device number is turned into a sparse select pattern: only the two top device numbers drive a select bit, and every other device leaves the upper address field clear. A downstream request is emitted as a Type 1 cycle with the bus, device, function and register fields carried through. An unclaimed read returns all ones. An unclaimed write completes quietly.

Each request ends with a one-cycle response pulse upstream. That pulse comes one cycle after the data phase ends, or one cycle after acceptance when there is no bus activity.

Top module: `cfgx_router`

## Requirements
- R1: After reset `req_ready` is 1 and `bus_addr_valid`, `bus_data_valid` and `rsp_valid` are 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 from the next cycle until the response cycle has passed.
- R2: Request word layout: bit 31 is the enable, bits 23:16 the bus, bits 15:11 the device, bits 10:8 the function, bits 7:2 the register DWord index. A request with bit 31 clear causes no bus activity, and is answered like an unclaimed request (see R6).
- R3: A request whose bus is 0, or equals `sec_bus`, is a Type 0 cycle. Equality with `sec_bus` takes priority over the downstream window. During the address phase `bus_ad[10:8]` is the function, `bus_ad[7:2]` is the register index and `bus_ad[1:0]` is 00.
- R4: In a Type 0 address phase, device 30 sets only `bus_ad[14]` within `bus_ad[31:11]`, and device 31 sets only `bus_ad[15]`. For devices 0 to 29, `bus_ad[31:11]` is all zero.
- R5: A request with `sec_bus < bus <= sub_bus` is a Type 1 cycle. The address phase has `bus_ad[31:24]` = 0, `bus_ad[23:16]` = bus, `bus_ad[15:11]` = device, `bus_ad[10:8]` = function, `bus_ad[7:2]` = register and `bus_ad[1:0]` = 01.
- R6: A request with a non-zero bus above `sub_bus`, or below `sec_bus`, is unclaimed. No address or data phase occurs. `rsp_valid` pulses in the cycle after acceptance, with `rsp_rdata` = FFFFFFFF for a read and 0 for a write.
- R7: A claimed request drives `bus_addr_valid` for exactly one cycle, starting the cycle after acceptance. `bus_data_valid` then holds from the next cycle until the edge that samples `bus_done`. Each request gets exactly one data phase.
- R8: During the data phase `bus_write` is 1 and `bus_ad` is the request's write data for a write. For a read, `bus_write` is 0 and `bus_ad` is 0. Both stay stable until `bus_done`.
- R9: For a claimed request, `rsp_valid` is a one-cycle pulse in the cycle after `bus_done` was sampled. `rsp_rdata` is the `bus_rdata` sampled with `bus_done` for a read, and 0 for a write.
- R10: Request bits 30:24 and 1:0 have no effect on routing or on the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_bus | input | 8 | Secondary (local) bus number |
| sub_bus | input | 8 | Subordinate (highest downstream) bus number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request can be taken |
| req_addr | input | 32 | Configuration address word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| bus_addr_valid | output | 1 | Address phase active |
| bus_data_valid | output | 1 | Data phase active |
| bus_write | output | 1 | Cycle direction on the segment |
| bus_ad | output | 32 | Multiplexed address/data |
| bus_done | input | 1 | Data phase complete |
| bus_rdata | input | 32 | Read data, valid with `bus_done` |
| rsp_valid | output | 1 | Response pulse upstream |
| rsp_rdata | output | 32 | Response read data |

## Verification
The address phase is due exactly one cycle after the accepting edge, and the first data-phase cycle one cycle after that. The response is due one cycle after the edge that samples `bus_done`, or one cycle after acceptance when the request is unclaimed. The bench drives inputs on falling edges and samples every output at the falling edge that lies inside the cycle where the result is due. It also checks the neighbouring cycles, so that a result arriving a cycle early or late, or lasting too long, is reported. The bus model holds off `bus_done` for a random number of cycles, which exercises data phases of different lengths.

// File: rtl/cfgx_pkg.sv
`timescale 1ns/1ps
package cfgx_pkg;

    // controller phases
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } cfgx_state_e;

    // routing outcome of one request
    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_LOCAL = 2'd1,
        RT_FWD   = 2'd2
    } cfgx_route_e;

    // field geometry of the request word
    localparam int ADW_DEF  = 32;
    localparam int BUSW_DEF = 8;
    localparam int DEVW_DEF = 5;
    localparam int FNW_DEF  = 3;
    localparam int REGW_DEF = 6;

endpackage

// File: rtl/cfgx_idsel.sv
`timescale 1ns/1ps
// Sparse device-select field for local cycles: N_SEL consecutive device
// numbers starting at FIRST_DEV each light one bit starting at FIRST_BIT.
module cfgx_idsel #(
    parameter int DEVW      = 5,
    parameter int SELW      = 21,
    parameter int FIRST_DEV = 30,
    parameter int FIRST_BIT = 3,
    parameter int N_SEL     = 2
) (
    input  logic [DEVW-1:0] dev,
    output logic [SELW-1:0] sel
);

    localparam int LAST_BIT = FIRST_BIT + N_SEL - 1;

    for (genvar j = 0; j < SELW; j++) begin : g_bit
        if (j >= FIRST_BIT && j <= LAST_BIT) begin : g_live
            localparam int DEV_NUM = FIRST_DEV + j - FIRST_BIT;
            assign sel[j] = (dev == DEVW'(DEV_NUM));
        end else begin : g_dead
            assign sel[j] = 1'b0;
        end
    end

endmodule

// File: rtl/cfgx_addr_dec.sv
`timescale 1ns/1ps
// Splits the request word, picks the route and builds the address phase.
module cfgx_addr_dec
    import cfgx_pkg::*;
#(
    parameter int ADW  = ADW_DEF,
    parameter int BUSW = BUSW_DEF,
    parameter int DEVW = DEVW_DEF,
    parameter int FNW  = FNW_DEF,
    parameter int REGW = REGW_DEF
) (
    input  logic [ADW-1:0]  req_addr,
    input  logic [BUSW-1:0] sec_bus,
    input  logic [BUSW-1:0] sub_bus,
    output cfgx_route_e     route,
    output logic [ADW-1:0]  xlat_addr
);

    localparam int REG_LSB = 2;
    localparam int FN_LSB  = REG_LSB + REGW;
    localparam int DEV_LSB = FN_LSB + FNW;
    localparam int BUS_LSB = DEV_LSB + DEVW;
    localparam int EN_BIT  = ADW - 1;
    localparam int SELW    = ADW - DEV_LSB;
    localparam int PADW    = ADW - (BUS_LSB + BUSW);
    localparam int TOP_DEV = (1 << DEVW) - 2;
    // select bit for the first sparse device sits at AD[14]
    localparam int SEL_BIT = 14 - DEV_LSB;

    logic            en;
    logic [BUSW-1:0] bus_n;
    logic [DEVW-1:0] dev_n;
    logic [FNW-1:0]  fn_n;
    logic [REGW-1:0] reg_n;
    logic [SELW-1:0] sel;
    logic            is_local;
    logic            in_window;

    assign en    = req_addr[EN_BIT];
    assign bus_n = req_addr[BUS_LSB +: BUSW];
    assign dev_n = req_addr[DEV_LSB +: DEVW];
    assign fn_n  = req_addr[FN_LSB +: FNW];
    assign reg_n = req_addr[REG_LSB +: REGW];

    cfgx_idsel #(
        .DEVW      (DEVW),
        .SELW      (SELW),
        .FIRST_DEV (TOP_DEV),
        .FIRST_BIT (SEL_BIT),
        .N_SEL     (2)
    ) idsel_i (
        .dev (dev_n),
        .sel (sel)
    );

    always_comb begin
        is_local  = (bus_n == '0) || (bus_n == sec_bus);
        in_window = (bus_n > sec_bus) && (bus_n <= sub_bus);
        if (!en) begin
            route = RT_NONE;
        end else if (is_local) begin
            route = RT_LOCAL;
        end else if (in_window) begin
            route = RT_FWD;
        end else begin
            route = RT_NONE;
        end
    end

    always_comb begin
        if (route == RT_FWD) begin
            xlat_addr = {{PADW{1'b0}}, bus_n, dev_n, fn_n, reg_n, 2'b01};
        end else begin
            xlat_addr = {sel, fn_n, reg_n, 2'b00};
        end
    end

endmodule

// File: rtl/cfgx_seq.sv
`timescale 1ns/1ps
// Single-DWord cycle sequencer: idle, address phase, data phase, done.
module cfgx_seq
    import cfgx_pkg::*;
#(
    parameter int ADW = ADW_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [ADW-1:0] req_wdata,
    input  cfgx_route_e    route,
    input  logic [ADW-1:0] xlat_addr,
    input  logic           bus_done,
    input  logic [ADW-1:0] bus_rdata,
    output logic           req_ready,
    output logic           bus_addr_valid,
    output logic           bus_data_valid,
    output logic           bus_write,
    output logic [ADW-1:0] bus_ad,
    output logic           rsp_valid,
    output logic [ADW-1:0] rsp_rdata
);

    typedef struct packed {
        cfgx_state_e    state;
        logic           write;
        logic [ADW-1:0] addr;
        logic [ADW-1:0] wdata;
        logic [ADW-1:0] rdata;
    } seq_regs_t;

    seq_regs_t r_d;
    seq_regs_t r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.write = req_write;
                    r_d.wdata = req_wdata;
                    r_d.addr  = xlat_addr;
                    if (route == RT_NONE) begin
                        r_d.rdata = req_write ? '0 : '1;
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (bus_done) begin
                    r_d.rdata = r_q.write ? '0 : bus_rdata;
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, write: 1'b0, addr: '0, wdata: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready      = (r_q.state == ST_IDLE);
        bus_addr_valid = (r_q.state == ST_ADDR);
        bus_data_valid = (r_q.state == ST_DATA);
        bus_write      = bus_data_valid && r_q.write;
        rsp_valid      = (r_q.state == ST_DONE);
        rsp_rdata      = rsp_valid ? r_q.rdata : '0;
        if (bus_addr_valid) begin
            bus_ad = r_q.addr;
        end else if (bus_write) begin
            bus_ad = r_q.wdata;
        end else begin
            bus_ad = '0;
        end
    end

endmodule

// File: rtl/cfgx_router.sv
`timescale 1ns/1ps
module cfgx_router
    import cfgx_pkg::*;
#(
    parameter int ADW  = ADW_DEF,
    parameter int BUSW = BUSW_DEF,
    parameter int DEVW = DEVW_DEF,
    parameter int FNW  = FNW_DEF,
    parameter int REGW = REGW_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BUSW-1:0] sec_bus,
    input  logic [BUSW-1:0] sub_bus,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [ADW-1:0]  req_addr,
    input  logic            req_write,
    input  logic [ADW-1:0]  req_wdata,
    output logic            bus_addr_valid,
    output logic            bus_data_valid,
    output logic            bus_write,
    output logic [ADW-1:0]  bus_ad,
    input  logic            bus_done,
    input  logic [ADW-1:0]  bus_rdata,
    output logic            rsp_valid,
    output logic [ADW-1:0]  rsp_rdata
);

    cfgx_route_e    route;
    logic [ADW-1:0] xlat_addr;

    cfgx_addr_dec #(
        .ADW  (ADW),
        .BUSW (BUSW),
        .DEVW (DEVW),
        .FNW  (FNW),
        .REGW (REGW)
    ) dec_i (
        .req_addr  (req_addr),
        .sec_bus   (sec_bus),
        .sub_bus   (sub_bus),
        .route     (route),
        .xlat_addr (xlat_addr)
    );

    cfgx_seq #(
        .ADW (ADW)
    ) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_wdata      (req_wdata),
        .route          (route),
        .xlat_addr      (xlat_addr),
        .bus_done       (bus_done),
        .bus_rdata      (bus_rdata),
        .req_ready      (req_ready),
        .bus_addr_valid (bus_addr_valid),
        .bus_data_valid (bus_data_valid),
        .bus_write      (bus_write),
        .bus_ad         (bus_ad),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata)
    );

endmodule

// File: rtl/cfgx_router_chk.sv
`timescale 1ns/1ps
module cfgx_router_chk #(
    parameter int ADW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic           bus_addr_valid,
    input logic           bus_data_valid,
    input logic           bus_write,
    input logic [ADW-1:0] bus_ad,
    input logic           bus_done,
    input logic           rsp_valid
);

    // R1: a taken request makes the router busy in the next cycle
    a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R1: idle means no bus activity and no response
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_addr_valid && !bus_data_valid && !rsp_valid);

    // R7: address phase lasts one cycle and is followed by the data phase
    a_r7_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_valid |=> !bus_addr_valid && bus_data_valid);

    // R7: phases never overlap
    a_r7_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_addr_valid && bus_data_valid));

    // R5/R3: address phase ends in 00 or 01
    a_r5_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_valid |-> !bus_ad[1]);

    // R4: local cycles light at most one select bit, only AD[15] or AD[14]
    a_r4_sparse_sel: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_valid && (bus_ad[1:0] == 2'b00) |->
            ($countones(bus_ad[31:11]) <= 1) && (bus_ad[31:16] == '0) && (bus_ad[13:11] == '0));

    // R8: data phase holds its drive until done
    a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_valid && !bus_done |=> bus_data_valid && $stable(bus_ad) && $stable(bus_write));

    // R9: done is answered in the next cycle by a single-cycle pulse
    a_r9_rsp_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_valid && bus_done |=> rsp_valid && !bus_data_valid);

    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

bind cfgx_router cfgx_router_chk #(.ADW(ADW)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .bus_addr_valid (bus_addr_valid),
    .bus_data_valid (bus_data_valid),
    .bus_write      (bus_write),
    .bus_ad         (bus_ad),
    .bus_done       (bus_done),
    .rsp_valid      (rsp_valid)
);

// File: tb/cfgx_router_tb_top.sv
`timescale 1ns/1ps
module cfgx_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sec_bus = 8'd0;
    logic [7:0]  sub_bus = 8'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_addr_valid;
    logic        bus_data_valid;
    logic        bus_write;
    logic [31:0] bus_ad;
    logic        bus_done = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    cfgx_router dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sec_bus        (sec_bus),
        .sub_bus        (sub_bus),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_write      (req_write),
        .req_wdata      (req_wdata),
        .bus_addr_valid (bus_addr_valid),
        .bus_data_valid (bus_data_valid),
        .bus_write      (bus_write),
        .bus_ad         (bus_ad),
        .bus_done       (bus_done),
        .bus_rdata      (bus_rdata),
        .rsp_valid      (rsp_valid),
        .rsp_rdata      (rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // 0 = unclaimed, 1 = local Type 0, 2 = downstream Type 1
    function automatic int exp_route(input logic [31:0] a, input logic [7:0] s, input logic [7:0] u);
        logic [7:0] b;
        b = a[23:16];
        if (!a[31]) return 0;
        if (b == 8'd0 || b == s) return 1;
        if (b > s && b <= u) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input int rt);
        logic [31:0] r;
        if (rt == 2) begin
            r = {8'h00, a[23:2], 2'b01};
        end else begin
            r = {21'd0, a[10:2], 2'b00};
            if (a[15:11] == 5'd30) r[14] = 1'b1;
            if (a[15:11] == 5'd31) r[15] = 1'b1;
        end
        return r;
    endfunction

    task automatic run_one(input logic [31:0] a, input bit w, input logic [31:0] wd,
                           input logic [31:0] rd, input int lat, input string tag);
        int rt;
        rt = exp_route(a, sec_bus, sub_bus);
        @(negedge clk);
        chk(req_ready == 1'b1, {"R1 ready before ", tag}, 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = w;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = $urandom;
        chk(req_ready == 1'b0, {"R1 busy after take ", tag}, 32'(req_ready), 32'd0);
        if (rt == 0) begin
            chk(!bus_addr_valid && !bus_data_valid, {"R6/R2 no bus activity ", tag},
                {30'd0, bus_addr_valid, bus_data_valid}, 32'd0);
            chk(rsp_valid == 1'b1, {"R6 response pulse ", tag}, 32'(rsp_valid), 32'd1);
            chk(rsp_rdata == (w ? 32'd0 : 32'hFFFF_FFFF), {"R6 unclaimed data ", tag},
                rsp_rdata, w ? 32'd0 : 32'hFFFF_FFFF);
        end else begin
            chk(bus_addr_valid == 1'b1, {"R7 address phase ", tag}, 32'(bus_addr_valid), 32'd1);
            chk(bus_ad == exp_addr(a, rt), {(rt == 2) ? "R5 type1 addr " : "R3/R4 type0 addr ", tag},
                bus_ad, exp_addr(a, rt));
            @(negedge clk);
            chk(!bus_addr_valid && bus_data_valid, {"R7 data phase follows ", tag},
                {30'd0, bus_addr_valid, bus_data_valid}, 32'd1);
            chk(bus_write == w && bus_ad == (w ? wd : 32'd0), {"R8 data drive ", tag},
                bus_ad, w ? wd : 32'd0);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk(bus_data_valid && !rsp_valid, {"R7 data phase held ", tag},
                    {30'd0, bus_data_valid, rsp_valid}, 32'd2);
            end
            bus_done  = 1'b1;
            bus_rdata = rd;
            @(negedge clk);
            bus_done  = 1'b0;
            bus_rdata = $urandom;
            chk(rsp_valid && !bus_data_valid, {"R9 response after done ", tag},
                {30'd0, rsp_valid, bus_data_valid}, 32'd2);
            chk(rsp_rdata == (w ? 32'd0 : rd), {"R9 response data ", tag},
                rsp_rdata, w ? 32'd0 : rd);
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready && !bus_addr_valid, {"R9 single pulse, idle again ", tag},
            {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] mk(input bit en, input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [5:0] r);
        return {en, 7'd0, b, d, f, r, 2'b00};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL R7 watchdog actual=hung expected=finished");
                $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(req_ready && !bus_addr_valid && !bus_data_valid && !rsp_valid, "R1 reset state",
            {28'd0, req_ready, bus_addr_valid, bus_data_valid, rsp_valid}, 32'h8);
        rst_n = 1'b1;
        sec_bus = 8'd5;
        sub_bus = 8'd9;

        // R4 sparse select, local bus
        run_one(mk(1, 8'd5, 5'd30, 3'd2, 6'd17), 0, 0, 32'h1234_5678, 0, "R4 dev30");
        run_one(mk(1, 8'd5, 5'd31, 3'd7, 6'd63), 1, 32'hCAFE_0001, 0, 2, "R4 dev31");
        run_one(mk(1, 8'd5, 5'd29, 3'd1, 6'd1), 0, 0, 32'hA5A5_5A5A, 1, "R4 dev29");
        run_one(mk(1, 8'd5, 5'd0, 3'd0, 6'd0), 0, 0, 32'h0000_0001, 0, "R4 dev0");
        // R3 bus 0 is local
        run_one(mk(1, 8'd0, 5'd31, 3'd3, 6'd5), 0, 0, 32'hDEAD_BEEF, 3, "R3 bus0");
        // R5 downstream, edges of window
        run_one(mk(1, 8'd6, 5'd30, 3'd4, 6'd9), 0, 0, 32'h0BAD_F00D, 0, "R5 low edge");
        run_one(mk(1, 8'd9, 5'd31, 3'd5, 6'd33), 1, 32'h1111_2222, 0, 1, "R5 high edge");
        // R6 unclaimed
        run_one(mk(1, 8'd10, 5'd1, 3'd0, 6'd0), 0, 0, 0, 0, "R6 above sub");
        run_one(mk(1, 8'd4, 5'd1, 3'd0, 6'd0), 1, 32'h55, 0, 0, "R6 below sec");
        // R2 enable clear
        run_one(mk(0, 8'd5, 5'd30, 3'd0, 6'd2), 0, 0, 0, 0, "R2 enable clear");
        // R3 priority: sec == sub
        sub_bus = 8'd5;
        run_one(mk(1, 8'd5, 5'd31, 3'd0, 6'd4), 0, 0, 32'h7777_0000, 0, "R3 sec equals sub");
        // R10 reserved bits ignored
        sub_bus = 8'd9;
        run_one(mk(1, 8'd7, 5'd12, 3'd6, 6'd40) | 32'h7F00_0003, 0, 0, 32'h0F0F_0F0F, 2, "R10 reserved");
        run_one(mk(1, 8'd5, 5'd30, 3'd6, 6'd40) | 32'h5A00_0002, 1, 32'h0ABC_DEF0, 0, 0, "R10 reserved local");

        // random mix
        for (int n = 0; n < 150; n++) begin
            int pick;
            logic [7:0] b;
            logic [4:0] d;
            sec_bus = 8'($urandom_range(1, 200));
            sub_bus = sec_bus + 8'($urandom_range(0, 20));
            pick = $urandom_range(0, 5);
            case (pick)
                0: b = 8'd0;
                1: b = sec_bus;
                2: b = 8'($urandom_range(int'(sec_bus), int'(sub_bus)));
                3: b = sub_bus + 8'd1;
                4: b = sec_bus - 8'd1;
                default: b = 8'($urandom_range(0, 255));
            endcase
            d = ($urandom_range(0, 2) == 0) ? 5'(30 + $urandom_range(0, 1)) : 5'($urandom_range(0, 31));
            a = mk($urandom_range(0, 7) != 0, b, d, 3'($urandom), 6'($urandom));
            a = a | ({$urandom} & 32'h7F00_0003);
            run_one(a, 1'($urandom), $urandom, $urandom, $urandom_range(0, 4), "random");
        end

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule